// File: doc/BRIEF.md
# Byte-Wide Host Access Port

This block gives an external host a window into the processor's local word memory through an 8-bit path. The host selects one of three views with a 2-bit register select: a control view, an address pointer and a data window. Every 16-bit quantity moves as two byte transfers. A half-select input marks each transfer as the first or the second byte, and a byte-order bit in the control view decides which half of the word the first byte stands for. The data window comes in two forms. One leaves the pointer alone. The other moves the pointer forward by one word after the second byte, so the host can stream through a buffer without reloading the pointer.

Host transfers are synchronous to the processor clock and use a valid/ready handshake. The host holds `h_valid` and its qualifiers steady until it sees `h_ready` high at a rising edge. That edge is the point of acceptance. Read bytes come back on `h_rdata` with a single-cycle `h_rvalid` pulse, and that pulse also serves as the drive enable for the external bidirectional pad. The port stops accepting transfers while a memory access it started is still open, and while the processor is held in reset. A data write reaches memory only once its second byte has arrived. A data read fetches the whole word when the first byte is asked for, and returns the second byte from a holding latch.

Toward memory, the block places a one-cycle host request ahead of the processor's own requests on a shared synchronous port. The control view carries two interrupt flags: a host-bound flag that the processor raises and the host clears, and a processor-bound request that the host raises and the processor clears.

Top module: `hostport8`

## Requirements
- R1: After reset the control bits read as 0 from both sides, the pointer is 0, both interrupt outputs are low, and `h_ready` is high once the processor is out of reset.
- R2: While `cpu_rst` is high, `h_ready` stays low and a transfer the host holds valid has no effect (for example, a control write of 0x03 leaves `cpu_irq` low).
- R3: Register select 2'b00 is control, 2'b01 is data with auto-increment, 2'b10 is the pointer and 2'b11 is data without increment. Control bit 0 is byte order. When it is 0, the transfer with `h_hilo`=0 carries bits 15:8. When it is 1, that transfer carries bits 7:0. The `h_hilo`=1 transfer always carries the other half.
- R4: A data write with `h_hilo`=0 only stores its byte. A data write with `h_hilo`=1 raises `mem_req` with `mem_we` in the next cycle. That access carries the assembled word and the pointer value at acceptance.
- R5: A data read with `h_hilo`=0 starts exactly one memory read of the word at the pointer. A data read with `h_hilo`=1 is served from the latched word and makes no memory access.
- R6: The pointer increments by 1 when a select-2'b01 access with `h_hilo`=1 is accepted. Select 2'b11 never changes it.
- R7: A host memory access takes precedence over a processor request in the same cycle. The processor is held off (`cpu_gnt` low) for exactly that one cycle, and `mem_addr` carries the host address during it.
- R8: Control bit 2 drives `host_irq`. The processor sets it by writing 1 to bit 2. The host clears it by writing 1 to bit 2, and a host write of 0 there leaves it unchanged.
- R9: Control bit 1 drives `cpu_irq`. The host sets it by writing 1 to bit 1, and the processor clears it by writing 1 to bit 1.
- R10: After a first-byte data read is accepted, `h_ready` is low in the following cycle. Each accepted read yields exactly one `h_rvalid` pulse carrying the byte. A control read returns {5'b0, bit2, bit1, bit0}.
- R11: When a set and a clear of the same interrupt flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Block reset, active low |
| cpu_rst | input | 1 | Processor reset is active; host transfers are refused |
| h_valid | input | 1 | Host transfer valid |
| h_ready | output | 1 | Port can accept a transfer |
| h_rw | input | 1 | 1 = read, 0 = write |
| h_sel | input | 2 | Register select (see R3) |
| h_hilo | input | 1 | 0 = first byte, 1 = second byte |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_rvalid | output | 1 | Read byte valid; pad drive enable |
| host_irq | output | 1 | Interrupt toward the host |
| cpu_irq | output | 1 | Interrupt toward the processor |
| cpu_ctl_we | input | 1 | Processor writes the control bits |
| cpu_ctl_wdata | input | 3 | Processor control write value |
| cpu_ctl_rdata | output | 3 | Control bits as seen by the processor |
| cpu_req | input | 1 | Processor memory request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | 16 | Processor write word |
| cpu_gnt | output | 1 | Processor request served this cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, one cycle after the request |

## Verification
Two collisions get direct stimulus. In the first, the processor holds a read request at another address while the host fetches a first byte. The bench counts the cycles in which `cpu_gnt` is withheld, expects exactly one, and checks that `mem_addr` carries the host pointer in that cycle. In the second, a host control write and a processor control write land on the same clock edge, one clearing an interrupt flag and the other setting it. The bench judges the result on `host_irq` and `cpu_irq`, which must read set one cycle later.

// File: rtl/hostport8_pkg.sv
package hostport8_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'b00,
    SEL_DINC = 2'b01,
    SEL_ADR  = 2'b10,
    SEL_DFIX = 2'b11
  } hsel_e;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'b00,
    HS_ISSUE = 2'b01,
    HS_WAIT  = 2'b10
  } hstate_e;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    if (hi) r[WORD_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0] = b;
    return r;
  endfunction
endpackage

// File: rtl/hpi_ctl.sv
module hpi_ctl
  import hostport8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [BYTE_W-1:0] h_wbyte,
  input  logic              c_we,
  input  logic [2:0]        c_wbits,
  output logic              bob,
  output logic              host_int,
  output logic              cpu_int,
  output logic [BYTE_W-1:0] ctl_byte
);
  logic hint_set, hint_clr, cint_set, cint_clr;

  always_comb begin
    hint_set = c_we & c_wbits[2];
    hint_clr = h_we & h_wbyte[2];
    cint_set = h_we & h_wbyte[1];
    cint_clr = c_we & c_wbits[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bob      <= 1'b0;
      host_int <= 1'b0;
      cpu_int  <= 1'b0;
    end else begin
      if (h_we)      bob <= h_wbyte[0];
      else if (c_we) bob <= c_wbits[0];
      if (hint_set)      host_int <= 1'b1;
      else if (hint_clr) host_int <= 1'b0;
      if (cint_set)      cpu_int <= 1'b1;
      else if (cint_clr) cpu_int <= 1'b0;
    end
  end

  assign ctl_byte = {{(BYTE_W-3){1'b0}}, host_int, cpu_int, bob};

  // R8
  host_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_wbyte[2] && !(c_we && c_wbits[2])) |=> !host_int);
  // R9
  cpu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_wbyte[1]) |=> cpu_int);
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_wbits[2] && h_we && h_wbyte[2]) |=> host_int);
endmodule

// File: rtl/hpi_host.sv
module hpi_host
  import hostport8_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rst,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_rw,
  input  logic [1:0]        h_sel,
  input  logic              h_hilo,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  output logic              h_rvalid,
  input  logic              bob,
  input  logic [BYTE_W-1:0] ctl_byte,
  output logic              ctl_we,
  output logic              hreq,
  output logic              hwe,
  output logic [ADDR_W-1:0] haddr,
  output logic [WORD_W-1:0] hwdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  hstate_e           state_q;
  logic [WORD_W-1:0] ar_q, lat_q, mc_addr_q;
  logic              mc_we_q, rd_hi_q, rvalid_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              accept, is_high, is_data, do_inc;
  hsel_e             sel;

  always_comb begin
    sel     = hsel_e'(h_sel);
    h_ready = rst_n & ~cpu_rst & (state_q == HS_IDLE);
    accept  = h_valid & h_ready;
    is_high = ~(h_hilo ^ bob);
    is_data = (sel == SEL_DINC) || (sel == SEL_DFIX);
    do_inc  = (sel == SEL_DINC);
    ctl_we  = accept & ~h_rw & (sel == SEL_CTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      ar_q      <= '0;
      lat_q     <= '0;
      mc_addr_q <= '0;
      mc_we_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (state_q)
        HS_IDLE: begin
          if (accept) begin
            if (sel == SEL_CTL) begin
              if (h_rw) begin
                rdata_q  <= ctl_byte;
                rvalid_q <= 1'b1;
              end
            end else if (sel == SEL_ADR) begin
              if (h_rw) begin
                rdata_q  <= pick_byte(ar_q, is_high);
                rvalid_q <= 1'b1;
              end else begin
                ar_q <= put_byte(ar_q, is_high, h_wdata);
              end
            end else if (is_data) begin
              if (!h_rw) begin
                lat_q <= put_byte(lat_q, is_high, h_wdata);
                if (h_hilo) begin
                  mc_we_q   <= 1'b1;
                  mc_addr_q <= ar_q;
                  state_q   <= HS_ISSUE;
                  if (do_inc) ar_q <= ar_q + 1'b1;
                end
              end else if (!h_hilo) begin
                mc_we_q   <= 1'b0;
                mc_addr_q <= ar_q;
                rd_hi_q   <= is_high;
                state_q   <= HS_ISSUE;
              end else begin
                rdata_q  <= pick_byte(lat_q, is_high);
                rvalid_q <= 1'b1;
                if (do_inc) ar_q <= ar_q + 1'b1;
              end
            end
          end
        end
        HS_ISSUE: state_q <= mc_we_q ? HS_IDLE : HS_WAIT;
        HS_WAIT: begin
          lat_q    <= mem_rdata;
          rdata_q  <= pick_byte(mem_rdata, rd_hi_q);
          rvalid_q <= 1'b1;
          state_q  <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  assign hreq     = (state_q == HS_ISSUE);
  assign hwe      = mc_we_q;
  assign haddr    = mc_addr_q[ADDR_W-1:0];
  assign hwdata   = lat_q;
  assign h_rdata  = rdata_q;
  assign h_rvalid = rvalid_q;

  // R4
  write_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && hwe) |-> $past(accept && !h_rw && h_hilo && is_data));
  // R5
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && !hwe) |-> $past(accept && h_rw && !h_hilo && is_data));
  // R6
  fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == SEL_DFIX) |=> $stable(ar_q));
  // R10
  busy_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && h_rw && !h_hilo && is_data) |=> !h_ready);
  // R7
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq |=> !hreq);
endmodule

// File: rtl/hpi_arb.sv
module hpi_arb
  import hostport8_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq,
  input  logic              hwe,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [WORD_W-1:0] hwdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  always_comb begin
    cpu_gnt = cpu_req & ~hreq;
    mem_req = hreq | cpu_req;
    if (hreq) begin
      mem_we    = hwe;
      mem_addr  = haddr;
      mem_wdata = hwdata;
    end else begin
      mem_we    = cpu_req & cpu_we;
      mem_addr  = cpu_addr;
      mem_wdata = cpu_wdata;
    end
  end

  // R7
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_gnt) |=> (cpu_gnt || !cpu_req));
endmodule

// File: rtl/hostport8.sv
module hostport8
  import hostport8_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rst,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_rw,
  input  logic [1:0]        h_sel,
  input  logic              h_hilo,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic              h_rvalid,
  output logic              host_irq,
  output logic              cpu_irq,
  input  logic              cpu_ctl_we,
  input  logic [2:0]        cpu_ctl_wdata,
  output logic [2:0]        cpu_ctl_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  logic              bob, host_int, cpu_int, ctl_we;
  logic [BYTE_W-1:0] ctl_byte;
  logic              hreq, hwe;
  logic [ADDR_W-1:0] haddr;
  logic [WORD_W-1:0] hwdata;

  hpi_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .h_we(ctl_we), .h_wbyte(h_wdata),
    .c_we(cpu_ctl_we), .c_wbits(cpu_ctl_wdata),
    .bob(bob), .host_int(host_int), .cpu_int(cpu_int), .ctl_byte(ctl_byte)
  );

  hpi_host #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst),
    .h_valid(h_valid), .h_ready(h_ready), .h_rw(h_rw), .h_sel(h_sel),
    .h_hilo(h_hilo), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .bob(bob), .ctl_byte(ctl_byte), .ctl_we(ctl_we),
    .hreq(hreq), .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .mem_rdata(mem_rdata)
  );

  hpi_arb #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .hreq(hreq), .hwe(hwe), .haddr(haddr), .hwdata(hwdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign host_irq      = host_int;
  assign cpu_irq       = cpu_int;
  assign cpu_ctl_rdata = ctl_byte[2:0];

  // R2
  refuse_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst && h_valid) |=> $stable(cpu_irq) || $past(cpu_ctl_we));
endmodule

// File: tb/hostport8_bench.sv
module hostport8_bench;
  import hostport8_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, cpu_rst = 1'b0;
  logic h_valid = 1'b0, h_rw = 1'b0, h_hilo = 1'b0;
  logic [1:0] h_sel = 2'b00;
  logic [7:0] h_wdata = '0, h_rdata;
  logic h_ready, h_rvalid, host_irq, cpu_irq;
  logic cpu_ctl_we = 1'b0;
  logic [2:0] cpu_ctl_wdata = '0, cpu_ctl_rdata;
  logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_gnt;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic bob_m = 1'b0;
  logic [7:0]  exp_rd[$];
  logic [31:0] exp_wr[$];
  logic [15:0] mem [256];
  logic [15:0] rd_q;
  int stall_cnt = 0, memreq_cnt = 0;
  logic [15:0] stall_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  hostport8 u_hostport8 (
    .clk(clk), .rst_n(rst_n), .cpu_rst(cpu_rst),
    .h_valid(h_valid), .h_ready(h_ready), .h_rw(h_rw), .h_sel(h_sel),
    .h_hilo(h_hilo), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .host_irq(host_irq), .cpu_irq(cpu_irq),
    .cpu_ctl_we(cpu_ctl_we), .cpu_ctl_wdata(cpu_ctl_wdata), .cpu_ctl_rdata(cpu_ctl_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_gnt(cpu_gnt), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = (16'(i) * 16'h0101) ^ 16'h5A3C;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      rd_q <= mem[mem_addr[7:0]];
    end
  end
  assign mem_rdata = rd_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: read bytes and memory writes against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) memreq_cnt++;
      if (cpu_req && !cpu_gnt) begin
        stall_cnt++;
        stall_addr = mem_addr;
      end
      if (h_rvalid) begin
        if (exp_rd.size() == 0) chk("R10 unexpected read byte", {24'b0, h_rdata}, 32'hFFFF_FFFF);
        else chk("R10/R5 read byte", {24'b0, h_rdata}, {24'b0, exp_rd.pop_front()});
      end
      if (mem_req && mem_we && !cpu_req) begin
        if (exp_wr.size() == 0) chk("R4 unexpected write", {mem_addr, mem_wdata}, 32'hFFFF_FFFF);
        else chk("R4 memory write", {mem_addr, mem_wdata}, exp_wr.pop_front());
      end
    end
  end

  function automatic logic [7:0] half(input logic [15:0] w, input logic hilo);
    return (~(hilo ^ bob_m)) ? w[15:8] : w[7:0];
  endfunction

  task automatic host_op(input logic [1:0] sel, input logic rw, input logic hilo,
                         input logic [7:0] wd);
    @(negedge clk);
    h_valid = 1'b1; h_sel = sel; h_rw = rw; h_hilo = hilo; h_wdata = wd;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    h_valid = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, input logic hilo, input logic [7:0] e);
    exp_rd.push_back(e);
    host_op(sel, 1'b1, hilo, 8'h00);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 h_ready", {31'b0, h_ready}, 1);
    chk("R1 host_irq", {31'b0, host_irq}, 0);
    chk("R1 cpu_irq", {31'b0, cpu_irq}, 0);
    chk("R1 cpu_ctl_rdata", {29'b0, cpu_ctl_rdata}, 0);
    host_rd(SEL_CTL, 1'b0, 8'h00);
    host_rd(SEL_ADR, 1'b0, 8'h00);
    host_rd(SEL_ADR, 1'b1, 8'h00);

    // R2 refusal while processor in reset
    @(negedge clk);
    cpu_rst = 1'b1;
    h_valid = 1'b1; h_sel = SEL_CTL; h_rw = 1'b0; h_hilo = 1'b0; h_wdata = 8'h03;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 h_ready low in reset", {31'b0, h_ready}, 0);
    end
    h_valid = 1'b0;
    cpu_rst = 1'b0;
    @(negedge clk);
    chk("R2 write ignored", {31'b0, cpu_irq}, 0);

    // R3 pointer write/read with byte order 0
    host_op(SEL_ADR, 1'b0, 1'b0, 8'h00);
    host_op(SEL_ADR, 1'b0, 1'b1, 8'h10);
    host_rd(SEL_ADR, 1'b1, 8'h10);
    host_rd(SEL_ADR, 1'b0, 8'h00);

    // R4 write on second byte, R6 fixed select keeps pointer
    host_op(SEL_DFIX, 1'b0, 1'b0, 8'hAB);
    exp_wr.push_back({16'h0010, 16'hABCD});
    host_op(SEL_DFIX, 1'b0, 1'b1, 8'hCD);
    settle(2);
    host_rd(SEL_ADR, 1'b1, 8'h10);

    // R5 / R6 auto-increment reads
    host_rd(SEL_DINC, 1'b0, 8'hAB);
    host_rd(SEL_DINC, 1'b1, 8'hCD);
    host_rd(SEL_DINC, 1'b0, half(mem[8'h11], 1'b0));
    host_rd(SEL_DINC, 1'b1, half(mem[8'h11], 1'b1));
    host_rd(SEL_ADR, 1'b1, 8'h12);

    // R3 byte order 1
    host_op(SEL_CTL, 1'b0, 1'b0, 8'h01);
    bob_m = 1'b1;
    host_rd(SEL_CTL, 1'b1, 8'h01);
    host_op(SEL_ADR, 1'b0, 1'b0, 8'h20);
    host_op(SEL_ADR, 1'b0, 1'b1, 8'h00);
    host_op(SEL_DFIX, 1'b0, 1'b0, 8'h34);
    exp_wr.push_back({16'h0020, 16'h1234});
    host_op(SEL_DFIX, 1'b0, 1'b1, 8'h12);
    settle(2);

    // R7 contention with processor, R10 busy after fetch
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0030;
    stall_cnt = 0;
    exp_rd.push_back(8'h34);
    h_valid = 1'b1; h_sel = SEL_DFIX; h_rw = 1'b1; h_hilo = 1'b0;
    chk("R10 ready before fetch", {31'b0, h_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    h_valid = 1'b0;
    chk("R10 ready low after fetch", {31'b0, h_ready}, 0);
    settle(4);
    chk("R7 one stall cycle", stall_cnt, 1);
    chk("R7 host address wins", {16'b0, stall_addr}, 32'h0020);
    cpu_req = 1'b0;
    @(negedge clk);
    snap = memreq_cnt;
    host_rd(SEL_DFIX, 1'b1, 8'h12);
    settle(2);
    chk("R5 second byte no memory access", memreq_cnt, snap);

    // R6 increment on write
    host_op(SEL_DINC, 1'b0, 1'b0, 8'h78);
    exp_wr.push_back({16'h0020, 16'h5678});
    host_op(SEL_DINC, 1'b0, 1'b1, 8'h56);
    host_rd(SEL_ADR, 1'b0, 8'h21);

    // R8 host interrupt flag
    @(negedge clk);
    cpu_ctl_we = 1'b1; cpu_ctl_wdata = 3'b101;
    @(negedge clk);
    cpu_ctl_we = 1'b0;
    chk("R8 host_irq set by cpu", {31'b0, host_irq}, 1);
    chk("R8 cpu_ctl_rdata", {29'b0, cpu_ctl_rdata}, 32'h5);
    host_op(SEL_CTL, 1'b0, 1'b0, 8'h01);
    chk("R8 write 0 keeps flag", {31'b0, host_irq}, 1);
    host_rd(SEL_CTL, 1'b0, 8'h05);
    host_op(SEL_CTL, 1'b0, 1'b0, 8'h05);
    chk("R8 host clears flag", {31'b0, host_irq}, 0);

    // R9 processor interrupt request
    host_op(SEL_CTL, 1'b0, 1'b0, 8'h03);
    chk("R9 cpu_irq set by host", {31'b0, cpu_irq}, 1);
    @(negedge clk);
    cpu_ctl_we = 1'b1; cpu_ctl_wdata = 3'b011;
    @(negedge clk);
    cpu_ctl_we = 1'b0;
    chk("R9 cpu clears request", {31'b0, cpu_irq}, 0);

    // R11 set and clear in the same cycle
    @(negedge clk);
    h_valid = 1'b1; h_sel = SEL_CTL; h_rw = 1'b0; h_hilo = 1'b0; h_wdata = 8'h05;
    cpu_ctl_we = 1'b1; cpu_ctl_wdata = 3'b101;
    chk("R11 ready for collision", {31'b0, h_ready}, 1);
    @(negedge clk);
    h_valid = 1'b0; cpu_ctl_we = 1'b0;
    chk("R11 host_irq set wins", {31'b0, host_irq}, 1);
    @(negedge clk);
    h_valid = 1'b1; h_wdata = 8'h03;
    cpu_ctl_we = 1'b1; cpu_ctl_wdata = 3'b011;
    @(negedge clk);
    h_valid = 1'b0; cpu_ctl_we = 1'b0;
    chk("R11 cpu_irq set wins", {31'b0, cpu_irq}, 1);

    settle(6);
    chk("R10 all reads returned", exp_rd.size(), 0);
    chk("R4 all writes seen", exp_wr.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule